// File: doc/BRIEF.md
# Burst Beat Address and Lane Walker

This block turns one AXI4 address-channel request into the sequence of per-beat byte addresses and byte-lane strobe masks that the data channel of that burst needs. It captures the start address, the beat count, the beat size and the burst kind when the request handshake completes. It then presents one beat at a time. A beat is retired when the consumer accepts it, and the final beat of the burst carries a last flag.

The FIXED, INCR and WRAP kinds are supported. Beats may be narrower than the bus, and a burst may start at an unaligned address. WRAP bursts fold back at their window boundary. Requests that cannot form a legal burst are refused with a one-cycle error pulse and produce no beats.

The write side and the read side are two independent copies of the same walker. Each has its own request and beat interfaces. A burst in progress on one side is never disturbed by anything on the other side.

Both interfaces follow valid/ready rules. A request is taken only in a cycle where `*_req_valid` and `*_req_ready` are both high. `*_req_ready` is high only while that side is idle. A beat is retired only in a cycle where `*_beat_valid` and `*_beat_ready` are both high. While `*_beat_ready` is held low, the current beat stays on the outputs unchanged for as long as the consumer holds off.

Top module: `burst_lane_walker`

## Requirements
- R1: A side accepts a request only when `req_valid` and `req_ready` are both high. `req_ready` is high exactly when the side has no burst in progress. The cycle after a legal request is accepted, `beat_valid` is high and `beat_addr` equals the start address.
- R2: For kind 2'b00 (FIXED), every beat carries the start address and the same strobe mask. For example, a 2-byte beat at address 0x2 on a 4-byte bus gives strobe 4'b1100 on every beat.
- R3: For kind 2'b01 (INCR), the address of each beat after the first is the previous beat address rounded down to the beat size, plus the beat size (2^size bytes). An unaligned start address therefore only affects the first beat.
- R4: For kind 2'b10 (WRAP), the window is the start address rounded down to beat size × beat count. A step that would reach the window end returns to the window base instead. For example, a 4-beat WRAP of 4-byte beats from 0x1018 visits 0x1018, 0x101C, 0x1010 and 0x1014.
- R5: Strobe bit i is set exactly when lane i lies between the address modulo the bus width and the next beat-size-aligned byte, without including that byte. For example, 1-byte INCR beats from 0x0 on a 4-byte bus give strobes 0001, 0010, 0100 and 1000.
- R6: A burst has `req_len`+1 beats. `beat_last` is high on the final beat only. After the final beat is accepted, the side is idle (`beat_valid` low, `req_ready` high) in the next cycle.
- R7: Kind 2'b11 is refused. `req_err` is high for one cycle, the cycle after the handshake, and no beat is produced.
- R8: A WRAP request whose `req_len` is not 1, 3, 7 or 15 is refused in the same way as R7.
- R9: A request whose beat size 2^size exceeds the bus width in bytes is refused in the same way as R7.
- R10: The write side and the read side each hold their own burst state. Requests, handshakes and beat acceptance on one side do not change the beat outputs of the other side.
- R11: While `beat_valid` is high and `beat_ready` is low, `beat_addr`, `beat_strb` and `beat_last` hold their values.
- R12: INCR bursts of every length from 1 to 256 beats run to completion, with `req_len` from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req_valid | input | 1 | Write request valid |
| wr_req_ready | output | 1 | Write side idle and able to take a request |
| wr_req_addr | input | ADDR_W | Write start byte address |
| wr_req_len | input | 8 | Write beat count minus one |
| wr_req_size | input | 3 | Write beat size exponent (bytes = 2^size) |
| wr_req_kind | input | 2 | Write burst kind: 00 FIXED, 01 INCR, 10 WRAP |
| wr_req_err | output | 1 | One-cycle pulse: write request refused |
| wr_beat_valid | output | 1 | Write beat present |
| wr_beat_ready | input | 1 | Consumer accepts the write beat |
| wr_beat_addr | output | ADDR_W | Write beat byte address |
| wr_beat_strb | output | DATA_BYTES | Write beat lane mask |
| wr_beat_last | output | 1 | Final write beat |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read side idle and able to take a request |
| rd_req_addr | input | ADDR_W | Read start byte address |
| rd_req_len | input | 8 | Read beat count minus one |
| rd_req_size | input | 3 | Read beat size exponent |
| rd_req_kind | input | 2 | Read burst kind |
| rd_req_err | output | 1 | One-cycle pulse: read request refused |
| rd_beat_valid | output | 1 | Read beat present |
| rd_beat_ready | input | 1 | Consumer accepts the read beat |
| rd_beat_addr | output | ADDR_W | Read beat byte address |
| rd_beat_strb | output | DATA_BYTES | Read beat lane mask |
| rd_beat_last | output | 1 | Final read beat |

## Verification
A corrupted address register or burst configuration appears on `beat_addr` and `beat_strb` no later than the beat after the fault. A wrong WRAP window shows up at the first fold, at most 16 beats in. A beat counter that is off by one moves `beat_last`, or changes when `req_ready` returns, at the end of the burst where it lies. Stalled beats show any register that drifts while it should hold, in the first stalled cycle. Running both sides at once exposes any state that leaks between them, because the parked side's beat then changes.

// File: rtl/blg_pkg.sv
package blg_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_BAD   = 2'b11
  } burst_kind_e;

  typedef struct packed {
    logic [7:0]  len;
    logic [2:0]  size;
    burst_kind_e kind;
  } burst_cfg_t;
endpackage

// File: rtl/blg_step.sv
// Next-beat address for the three burst kinds.
module blg_step
  import blg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  burst_cfg_t        cfg,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] bsz, aligned, stepped, span, base;

  always_comb begin
    bsz     = ADDR_W'(1) << cfg.size;
    aligned = cur_addr & ~(bsz - ADDR_W'(1));
    stepped = aligned + bsz;
    span    = bsz * (ADDR_W'(cfg.len) + ADDR_W'(1));
    base    = cur_addr & ~(span - ADDR_W'(1));
    unique case (cfg.kind)
      BK_INCR: nxt_addr = stepped;
      BK_WRAP: nxt_addr = (stepped == base + span) ? base : stepped;
      default: nxt_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/blg_lanes.sv
// Lane mask: from the byte offset up to the next beat-size boundary.
module blg_lanes #(
  parameter int DATA_BYTES = 4,
  localparam int OFS_W = $clog2(DATA_BYTES)
) (
  input  logic [OFS_W-1:0]      ofs,
  input  logic [2:0]            size,
  output logic [DATA_BYTES-1:0] strb
);
  logic [OFS_W:0] bsz, lo, hi;

  always_comb begin
    bsz = (OFS_W+1)'(1) << size;
    lo  = {1'b0, ofs};
    hi  = ({1'b0, ofs} & ~(bsz - (OFS_W+1)'(1))) + bsz;
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    assign strb[i] = ((OFS_W+1)'(i) >= lo) && ((OFS_W+1)'(i) < hi);
  end
endmodule

// File: rtl/blg_channel.sv
// One burst context: request capture, beat counter, beat outputs.
module blg_channel
  import blg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  localparam int OFS_W     = $clog2(DATA_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [7:0]            req_len,
  input  logic [2:0]            req_size,
  input  logic [1:0]            req_kind,
  output logic                  req_err,
  output logic                  beat_valid,
  input  logic                  beat_ready,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic                  beat_last
);
  logic              busy_q, err_q;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [7:0]        cnt_q;
  burst_cfg_t        cfg_q;
  logic              accept, bad_kind, bad_size, bad_wrap, refuse, last;

  always_comb begin
    accept   = req_valid && !busy_q;
    bad_kind = (req_kind == 2'b11);
    bad_size = (int'(req_size) > OFS_W);
    bad_wrap = (req_kind == 2'b10) &&
               !(req_len == 8'd1 || req_len == 8'd3 ||
                 req_len == 8'd7 || req_len == 8'd15);
    refuse   = bad_kind || bad_size || bad_wrap;
    last     = (cnt_q == cfg_q.len);
  end

  blg_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (addr_q),
    .cfg      (cfg_q),
    .nxt_addr (nxt_addr)
  );

  blg_lanes #(.DATA_BYTES(DATA_BYTES)) u_lanes (
    .ofs  (addr_q[OFS_W-1:0]),
    .size (cfg_q.size),
    .strb (beat_strb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      cfg_q  <= '{len: 8'd0, size: 3'd0, kind: BK_FIXED};
    end else begin
      err_q <= accept && refuse;
      if (accept && !refuse) begin
        busy_q <= 1'b1;
        addr_q <= req_addr;
        cnt_q  <= '0;
        cfg_q  <= '{len: req_len, size: req_size, kind: burst_kind_e'(req_kind)};
      end else if (busy_q && beat_ready) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_q + 8'd1;
          addr_q <= nxt_addr;
        end
      end
    end
  end

  assign req_ready  = !busy_q;
  assign req_err    = err_q;
  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign beat_last  = busy_q && last;

  // Assertions
  logic [ADDR_W-1:0] span_now;
  assign span_now = (ADDR_W'(1) << cfg_q.size) * (ADDR_W'(cfg_q.len) + ADDR_W'(1));

  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
                                  $stable(beat_strb) && $stable(beat_last));

  a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> !beat_valid && req_ready);

  a_r2_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last && cfg_q.kind == BK_FIXED
      |=> beat_addr == $past(beat_addr));

  a_r4_wrap_window: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last && cfg_q.kind == BK_WRAP
      |=> ((beat_addr ^ $past(beat_addr)) & ~($past(span_now) - ADDR_W'(1))) == '0);

  a_r7_refuse_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !beat_valid && req_ready);

  a_r5_strb_sane: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_strb != '0 &&
                   $countones(beat_strb) <= (32'd1 << cfg_q.size));

  a_r1_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !refuse |=> beat_valid && beat_addr == $past(req_addr));
endmodule

// File: rtl/burst_lane_walker.sv
// Write and read burst walkers, fully separate contexts.
module burst_lane_walker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req_valid,
  output logic                  wr_req_ready,
  input  logic [ADDR_W-1:0]     wr_req_addr,
  input  logic [7:0]            wr_req_len,
  input  logic [2:0]            wr_req_size,
  input  logic [1:0]            wr_req_kind,
  output logic                  wr_req_err,
  output logic                  wr_beat_valid,
  input  logic                  wr_beat_ready,
  output logic [ADDR_W-1:0]     wr_beat_addr,
  output logic [DATA_BYTES-1:0] wr_beat_strb,
  output logic                  wr_beat_last,
  input  logic                  rd_req_valid,
  output logic                  rd_req_ready,
  input  logic [ADDR_W-1:0]     rd_req_addr,
  input  logic [7:0]            rd_req_len,
  input  logic [2:0]            rd_req_size,
  input  logic [1:0]            rd_req_kind,
  output logic                  rd_req_err,
  output logic                  rd_beat_valid,
  input  logic                  rd_beat_ready,
  output logic [ADDR_W-1:0]     rd_beat_addr,
  output logic [DATA_BYTES-1:0] rd_beat_strb,
  output logic                  rd_beat_last
);
  // R10: each side owns an instance; no state is shared.
  blg_channel #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_wr (
    .clk, .rst_n,
    .req_valid (wr_req_valid), .req_ready (wr_req_ready),
    .req_addr  (wr_req_addr),  .req_len   (wr_req_len),
    .req_size  (wr_req_size),  .req_kind  (wr_req_kind),
    .req_err   (wr_req_err),
    .beat_valid(wr_beat_valid), .beat_ready(wr_beat_ready),
    .beat_addr (wr_beat_addr),  .beat_strb (wr_beat_strb),
    .beat_last (wr_beat_last)
  );

  blg_channel #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_rd (
    .clk, .rst_n,
    .req_valid (rd_req_valid), .req_ready (rd_req_ready),
    .req_addr  (rd_req_addr),  .req_len   (rd_req_len),
    .req_size  (rd_req_size),  .req_kind  (rd_req_kind),
    .req_err   (rd_req_err),
    .beat_valid(rd_beat_valid), .beat_ready(rd_beat_ready),
    .beat_addr (rd_beat_addr),  .beat_strb (rd_beat_strb),
    .beat_last (rd_beat_last)
  );
endmodule

// File: tb/tb_burst_lane_walker.sv
module tb_burst_lane_walker;
  localparam int AW = 32;
  localparam int DB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          req_valid [2];
  logic          req_ready [2];
  logic [AW-1:0] req_addr  [2];
  logic [7:0]    req_len   [2];
  logic [2:0]    req_size  [2];
  logic [1:0]    req_kind  [2];
  logic          req_err   [2];
  logic          beat_valid[2];
  logic          beat_ready[2];
  logic [AW-1:0] beat_addr [2];
  logic [DB-1:0] beat_strb [2];
  logic          beat_last [2];

  burst_lane_walker #(.ADDR_W(AW), .DATA_BYTES(DB)) dut (
    .clk, .rst_n,
    .wr_req_valid(req_valid[0]), .wr_req_ready(req_ready[0]),
    .wr_req_addr(req_addr[0]), .wr_req_len(req_len[0]),
    .wr_req_size(req_size[0]), .wr_req_kind(req_kind[0]),
    .wr_req_err(req_err[0]),
    .wr_beat_valid(beat_valid[0]), .wr_beat_ready(beat_ready[0]),
    .wr_beat_addr(beat_addr[0]), .wr_beat_strb(beat_strb[0]),
    .wr_beat_last(beat_last[0]),
    .rd_req_valid(req_valid[1]), .rd_req_ready(req_ready[1]),
    .rd_req_addr(req_addr[1]), .rd_req_len(req_len[1]),
    .rd_req_size(req_size[1]), .rd_req_kind(req_kind[1]),
    .rd_req_err(req_err[1]),
    .rd_beat_valid(beat_valid[1]), .rd_beat_ready(beat_ready[1]),
    .rd_beat_addr(beat_addr[1]), .rd_beat_strb(beat_strb[1]),
    .rd_beat_last(beat_last[1])
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model from the requirements
  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic [7:0] l,
                                             logic [2:0] s, logic [1:0] k, int n);
    logic [AW-1:0] bsz = AW'(1) << s;
    logic [AW-1:0] al  = a - (a % bsz);
    logic [AW-1:0] tot = bsz * (AW'(l) + 1);
    logic [AW-1:0] bnd = a - (a % tot);
    if (n == 0 || k == 2'b00) return a;
    if (k == 2'b01) return al + AW'(n) * bsz;
    return bnd + ((al - bnd + AW'(n) * bsz) % tot);
  endfunction

  function automatic logic [DB-1:0] exp_strb(logic [AW-1:0] a, logic [2:0] s);
    int bsz = 1 << s;
    int lo  = int'(a % DB);
    int hi  = int'((a - (a % bsz)) % DB) + bsz;
    logic [DB-1:0] m = '0;
    for (int i = 0; i < DB; i++) m[i] = (i >= lo && i < hi);
    return m;
  endfunction

  function automatic bit is_bad(logic [7:0] l, logic [2:0] s, logic [1:0] k);
    if (k == 2'b11) return 1;
    if ((1 << s) > DB) return 1;
    if (k == 2'b10 && !(l == 1 || l == 3 || l == 7 || l == 15)) return 1;
    return 0;
  endfunction

  task automatic present(int ch, logic [AW-1:0] a, logic [7:0] l, logic [2:0] s, logic [1:0] k);
    req_addr[ch] = a; req_len[ch] = l; req_size[ch] = s; req_kind[ch] = k;
    req_valid[ch] = 1'b1;
  endtask

  task automatic check_beat(int ch, logic [AW-1:0] a, logic [7:0] l, logic [2:0] s,
                            logic [1:0] k, int n, string tag);
    logic [AW-1:0] ea = exp_addr(a, l, s, k, n);
    chk(beat_valid[ch] == 1'b1, tag, "beat_valid", 64'(beat_valid[ch]), 64'd1);
    chk(beat_addr[ch] == ea, tag, "beat_addr", 64'(beat_addr[ch]), 64'(ea));
    chk(beat_strb[ch] == exp_strb(ea, s), "R5", "beat_strb",
        64'(beat_strb[ch]), 64'(exp_strb(ea, s)));
    chk(beat_last[ch] == (n == int'(l)), "R6", "beat_last",
        64'(beat_last[ch]), 64'(n == int'(l)));
  endtask

  task automatic run_burst(int ch, logic [AW-1:0] a, logic [7:0] l, logic [2:0] s,
                           logic [1:0] k, int stall_pct, string tag);
    @(negedge clk);
    chk(req_ready[ch] == 1'b1, "R1", "req_ready idle", 64'(req_ready[ch]), 64'd1);
    present(ch, a, l, s, k);
    @(negedge clk);
    req_valid[ch] = 1'b0;
    if (is_bad(l, s, k)) begin
      chk(req_err[ch] == 1'b1 && beat_valid[ch] == 1'b0, tag, "refuse err/valid",
          {62'd0, req_err[ch], beat_valid[ch]}, 64'b10);
      @(negedge clk);
      chk(req_err[ch] == 1'b0 && req_ready[ch] == 1'b1, tag, "after refuse err/ready",
          {62'd0, req_err[ch], req_ready[ch]}, 64'b01);
      return;
    end
    chk(req_err[ch] == 1'b0 && req_ready[ch] == 1'b0, "R1", "accepted err/ready",
        {62'd0, req_err[ch], req_ready[ch]}, 64'b00);
    for (int n = 0; n <= int'(l); n++) begin
      while (int'($urandom % 100) < stall_pct) begin
        check_beat(ch, a, l, s, k, n, "R11");
        @(negedge clk);
      end
      check_beat(ch, a, l, s, k, n, tag);
      beat_ready[ch] = 1'b1;
      @(negedge clk);
      beat_ready[ch] = 1'b0;
    end
    chk(beat_valid[ch] == 1'b0 && req_ready[ch] == 1'b1, "R6", "idle after last",
        {62'd0, beat_valid[ch], req_ready[ch]}, 64'b01);
  endtask

  bit done = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 2; c++) begin
      req_valid[c] = 0; beat_ready[c] = 0; req_addr[c] = '0;
      req_len[c] = '0; req_size[c] = '0; req_kind[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      chk(req_ready[c] && !beat_valid[c] && !req_err[c], "R1", "reset state",
          {61'd0, req_ready[c], beat_valid[c], req_err[c]}, 64'b100);

    // Directed corners
    run_burst(0, 32'h1018, 8'd3, 3'd2, 2'b10, 0, "R4");
    run_burst(1, 32'h0002, 8'd3, 3'd1, 2'b00, 30, "R2");
    run_burst(0, 32'h0000, 8'd3, 3'd0, 2'b01, 0, "R5");
    run_burst(1, 32'h0001, 8'd4, 3'd2, 2'b01, 20, "R3");
    run_burst(0, 32'h0106, 8'd7, 3'd1, 2'b10, 10, "R4");
    run_burst(1, 32'h0040, 8'd255, 3'd2, 2'b01, 0, "R12");
    run_burst(0, 32'h0003, 8'd0, 3'd0, 2'b01, 0, "R12");
    run_burst(0, 32'h0010, 8'd2, 3'd2, 2'b11, 0, "R7");
    run_burst(1, 32'h0010, 8'd2, 3'd1, 2'b10, 0, "R8");
    run_burst(1, 32'h0010, 8'd31, 3'd0, 2'b10, 0, "R8");
    run_burst(0, 32'h0010, 8'd3, 3'd3, 2'b01, 0, "R9");

    // R10: both sides busy at once; read runs while write is parked
    @(negedge clk);
    present(0, 32'h2004, 8'd3, 3'd2, 2'b01);
    present(1, 32'h3001, 8'd2, 3'd0, 2'b00);
    @(negedge clk);
    req_valid[0] = 0; req_valid[1] = 0;
    for (int n = 0; n <= 2; n++) begin
      check_beat(1, 32'h3001, 8'd2, 3'd0, 2'b00, n, "R10");
      check_beat(0, 32'h2004, 8'd3, 3'd2, 2'b01, 0, "R10");
      beat_ready[1] = 1;
      @(negedge clk);
      beat_ready[1] = 0;
    end
    // refused read request must not disturb the parked write beat
    present(1, 32'h0, 8'd0, 3'd0, 2'b11);
    @(negedge clk);
    req_valid[1] = 0;
    check_beat(0, 32'h2004, 8'd3, 3'd2, 2'b01, 0, "R10");
    for (int n = 0; n <= 3; n++) begin
      check_beat(0, 32'h2004, 8'd3, 3'd2, 2'b01, n, "R10");
      beat_ready[0] = 1;
      @(negedge clk);
      beat_ready[0] = 0;
    end
    chk(!beat_valid[0] && !beat_valid[1], "R10", "both idle",
        {62'd0, beat_valid[0], beat_valid[1]}, 64'd0);

    // Constrained random
    for (int t = 0; t < 120; t++) begin
      int ch = int'($urandom % 2);
      logic [1:0] k = 2'($urandom % 4);
      logic [2:0] s = ($urandom % 10 == 0) ? 3'd3 : 3'($urandom % 3);
      logic [7:0] l;
      logic [AW-1:0] a = AW'($urandom % 32'h10000);
      if (k == 2'b10) begin
        case ($urandom % 5)
          0: l = 8'd1; 1: l = 8'd3; 2: l = 8'd7; 3: l = 8'd15;
          default: l = 8'($urandom % 20);
        endcase
        if ($urandom % 2 == 0) a = a & ~((AW'(1) << s) - 1);
      end else begin
        l = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 12);
      end
      run_burst(ch, a, l, s, k, 25, k == 2'b00 ? "R2" : k == 2'b01 ? "R3" : "R4");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule